// File: doc/BRIEF.md
# Masked Content-Addressable Memory

This block is a synchronous associative store. Each entry is one data word with its own validity flag. A command port writes, reads or invalidates single entries by address. A search port presents a comparand together with a bit mask. In every cycle that a search is requested, every stored word is compared at once against the comparand, and only on the bit positions the mask enables.

The per-entry match flags, gated by validity, feed a priority encoder. The encoder keeps the lowest-numbered matching entry. The hit flag and the winning address are registered and appear on the result port one clock after the request. With the default parameters the array is 512 entries of 64 bits and uses a 9-bit address. Depth and word width are parameters, and the address width is derived from the depth.

Top module: `cam_array`

## Requirements
- R1: After reset every validity flag is clear, so any search misses, even one whose mask is all zeros, until an entry is written.
- R2: A write command (op code 2'b01) stores the data at the addressed entry and sets its validity flag. A later read command (op code 2'b10) returns that word and the flag on the read outputs one cycle after the read.
- R3: An invalidate command (op code 2'b11) clears the validity flag of the addressed entry. The stored word is left as it was, and a read returns it with the flag low.
- R4: A search compares only the bit positions where the mask bit is 1. Positions with a mask bit of 0 never prevent a match, so an all-zero mask matches every valid entry.
- R5: An entry whose validity flag is clear never produces a hit.
- R6: When several valid entries match, the reported address is the lowest-numbered one among them.
- R7: When no valid entry matches, the hit output is 0 and the address output is 0.
- R8: Search results appear on the result outputs in the cycle after the search request. They hold their value in cycles without a request.
- R9: A search issued in the same cycle as a write or invalidate sees the array contents from before that command.
- R10: The read outputs change only in the cycle after a read command. Otherwise they hold their value. The no-op code is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_op | input | 2 | Command: 00 none, 01 write, 10 read, 11 invalidate |
| cmd_addr | input | 9 | Entry addressed by the command |
| cmd_wdata | input | 64 | Word stored by a write |
| rd_data | output | 64 | Word returned by the last read |
| rd_valid | output | 1 | Validity flag returned by the last read |
| srch_en | input | 1 | Search request |
| srch_key | input | 64 | Comparand |
| srch_mask | input | 64 | Per-bit compare enable, 1 = compared |
| res_hit | output | 1 | At least one valid entry matched |
| res_addr | output | 9 | Lowest matching address, 0 on a miss |

## Verification
The assertions assume that the command code is always one of the four defined values. They also assume that the command and search inputs are stable and known around each rising edge while reset is released, and that nothing is issued in the cycle reset is deasserted. The bench drives every input on the falling edge and keeps the command idle through reset and for one cycle after it. Its random traffic uses only the four defined op codes. Addresses are drawn from a small pool plus the two extreme entries, and keys from a few values, so that multiple matches, misses and collisions between commands and searches happen often.

// File: rtl/cam_pkg.sv
package cam_pkg;
   typedef enum logic [1:0] {
      CMD_NOP   = 2'b00,
      CMD_WRITE = 2'b01,
      CMD_READ  = 2'b10,
      CMD_INVAL = 2'b11
   } cam_cmd_e;
endpackage

// File: rtl/cam_store.sv
module cam_store
   import cam_pkg::*;
#(
   parameter int DEPTH  = 512,
   parameter int WIDTH  = 64,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [WIDTH-1:0]  cmd_wdata,
   output logic [WIDTH-1:0]  words [DEPTH],
   output logic [DEPTH-1:0]  vld,
   output logic [WIDTH-1:0]  rd_data,
   output logic              rd_valid
);
   cam_cmd_e op;
   assign op = cam_cmd_e'(cmd_op);

   logic [WIDTH-1:0] mem_q [DEPTH];
   logic [DEPTH-1:0] vld_q;

   always_ff @(posedge clk) begin
      if (op == CMD_WRITE) mem_q[cmd_addr] <= cmd_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else if (op == CMD_WRITE) begin
         vld_q[cmd_addr] <= 1'b1;
      end else if (op == CMD_INVAL) begin
         vld_q[cmd_addr] <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else if (op == CMD_READ) begin
         rd_data  <= mem_q[cmd_addr];
         rd_valid <= vld_q[cmd_addr];
      end
   end

   assign words = mem_q;
   assign vld   = vld_q;

   AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (vld_q == '0)); // R1
   AST_WRITE_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (op == CMD_WRITE) |=> vld_q[$past(cmd_addr)]); // R2
   AST_INVAL_CLEARS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (op == CMD_INVAL) |=> !vld_q[$past(cmd_addr)]); // R3
   AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (op != CMD_READ) |=> ($stable(rd_data) && $stable(rd_valid))); // R10
endmodule

// File: rtl/cam_match.sv
module cam_match #(
   parameter int DEPTH = 512,
   parameter int WIDTH = 64
) (
   input  logic [WIDTH-1:0] words [DEPTH],
   input  logic [DEPTH-1:0] vld,
   input  logic [WIDTH-1:0] key,
   input  logic [WIDTH-1:0] mask,
   output logic [DEPTH-1:0] hits
);
   for (genvar g = 0; g < DEPTH; g++) begin : g_entry
      logic [WIDTH-1:0] diff;
      assign diff    = (words[g] ^ key) & mask;
      assign hits[g] = vld[g] & ~(|diff);
   end
endmodule

// File: rtl/cam_prio.sv
module cam_prio #(
   parameter int DEPTH  = 512,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic [DEPTH-1:0]  hits,
   output logic              any,
   output logic [ADDR_W-1:0] idx
);
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (hits[i]) begin
            any = 1'b1;
            idx = ADDR_W'(i);
         end
      end
   end

   logic [DEPTH-1:0] below;
   assign below = ({{(DEPTH-1){1'b0}}, 1'b1} << idx) - 1'b1;

   always_comb begin
      if (any) begin
         AST_PRIO_LOWEST: assert (hits[idx] && ((hits & below) == '0)); // R6
      end
   end
endmodule

// File: rtl/cam_array.sv
module cam_array #(
   parameter int DEPTH  = 512,
   parameter int WIDTH  = 64,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [WIDTH-1:0]  cmd_wdata,
   output logic [WIDTH-1:0]  rd_data,
   output logic              rd_valid,
   input  logic              srch_en,
   input  logic [WIDTH-1:0]  srch_key,
   input  logic [WIDTH-1:0]  srch_mask,
   output logic              res_hit,
   output logic [ADDR_W-1:0] res_addr
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("cam_array: DEPTH must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("cam_array: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0]  words [DEPTH];
   logic [DEPTH-1:0]  vld;
   logic [DEPTH-1:0]  hits;
   logic              any;
   logic [ADDR_W-1:0] idx;

   cam_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_op    (cmd_op),
      .cmd_addr  (cmd_addr),
      .cmd_wdata (cmd_wdata),
      .words     (words),
      .vld       (vld),
      .rd_data   (rd_data),
      .rd_valid  (rd_valid)
   );

   cam_match #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_match (
      .words (words),
      .vld   (vld),
      .key   (srch_key),
      .mask  (srch_mask),
      .hits  (hits)
   );

   cam_prio #(.DEPTH(DEPTH)) u_prio (
      .hits (hits),
      .any  (any),
      .idx  (idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_hit  <= 1'b0;
         res_addr <= '0;
      end else if (srch_en) begin
         res_hit  <= any;
         res_addr <= idx;
      end
   end

   AST_MISS_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !res_hit |-> (res_addr == '0)); // R7
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !srch_en |=> ($stable(res_hit) && $stable(res_addr))); // R8
endmodule

// File: tb/tb_cam_array.sv
module tb_cam_array;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 512;
   localparam int WIDTH = 64;
   localparam int AW = 9;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] cmd_op = 2'b00;
   logic [AW-1:0] cmd_addr = '0;
   logic [WIDTH-1:0] cmd_wdata = '0;
   logic srch_en = 1'b0;
   logic [WIDTH-1:0] srch_key = '0;
   logic [WIDTH-1:0] srch_mask = '0;
   logic [WIDTH-1:0] rd_data;
   logic rd_valid;
   logic res_hit;
   logic [AW-1:0] res_addr;

   always #(CLK_PERIOD/2) clk = ~clk;

   cam_array dut (
      .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
      .cmd_wdata(cmd_wdata), .rd_data(rd_data), .rd_valid(rd_valid),
      .srch_en(srch_en), .srch_key(srch_key), .srch_mask(srch_mask),
      .res_hit(res_hit), .res_addr(res_addr)
   );

   // reference model
   logic [WIDTH-1:0] m_mem [DEPTH];
   bit m_vld [DEPTH];
   bit e_hit;
   int e_addr;
   logic [WIDTH-1:0] e_rd;
   bit e_rdv;
   string cur_req = "R1";
   string s_req = "R1";
   string r_req = "R1";
   int n_checks = 0;
   int n_fail = 0;
   bit finished = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) m_vld[i] = 0;
         e_hit = 0; e_addr = 0; e_rd = '0; e_rdv = 0;
      end else begin
         if (srch_en) begin
            e_hit = 0; e_addr = 0;
            for (int i = 0; i < DEPTH; i++) begin
               if (!e_hit && m_vld[i] && (((m_mem[i] ^ srch_key) & srch_mask) == '0)) begin
                  e_hit = 1; e_addr = i;
               end
            end
            s_req = cur_req;
         end
         if (cmd_op == 2'b10) begin
            e_rd = m_mem[cmd_addr]; e_rdv = m_vld[cmd_addr];
            r_req = cur_req;
         end
         if (cmd_op == 2'b01) begin
            m_mem[cmd_addr] = cmd_wdata; m_vld[cmd_addr] = 1;
         end else if (cmd_op == 2'b11) begin
            m_vld[cmd_addr] = 0;
         end
      end
   end

   always @(negedge clk) begin
      if (!finished) begin
         n_checks++;
         if (res_hit !== e_hit || res_addr !== AW'(e_addr)) begin
            n_fail++;
            $display("FAIL %s search: hit=%0b addr=%0d expected hit=%0b addr=%0d",
                     s_req, res_hit, res_addr, e_hit, e_addr);
         end
         n_checks++;
         if (rd_data !== e_rd || rd_valid !== e_rdv) begin
            n_fail++;
            $display("FAIL %s read: data=%h vld=%0b expected data=%h vld=%0b",
                     r_req, rd_data, rd_valid, e_rd, e_rdv);
         end
      end
   end

   task automatic step(input logic [1:0] op, input int addr, input logic [WIDTH-1:0] d,
                       input bit se, input logic [WIDTH-1:0] k, input logic [WIDTH-1:0] m);
      @(negedge clk);
      #1;
      cmd_op = op; cmd_addr = AW'(addr); cmd_wdata = d;
      srch_en = se; srch_key = k; srch_mask = m;
   endtask

   localparam logic [WIDTH-1:0] A = 64'hDEAD_BEEF_0123_4567;
   localparam logic [WIDTH-1:0] B = 64'h0F0F_0000_FFFF_1234;
   localparam logic [WIDTH-1:0] C = 64'h1111_2222_3333_4444;
   localparam logic [WIDTH-1:0] ALL = '1;

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         finished = 1;
         n_checks++; n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: empty after reset, even mask zero misses
      cur_req = "R1";
      step(2'b00, 0, '0, 1, '0, '0);
      step(2'b00, 0, '0, 1, A, ALL);
      // R2: writes and reads
      cur_req = "R2";
      step(2'b01, 5, A, 0, '0, '0);
      step(2'b01, 9, A, 0, '0, '0);
      step(2'b01, 3, B, 0, '0, '0);
      step(2'b01, 0, C ^ 64'h1, 0, '0, '0);
      step(2'b01, 511, C, 0, '0, '0);
      step(2'b10, 5, '0, 0, '0, '0);
      step(2'b10, 511, '0, 0, '0, '0);
      step(2'b10, 7, '0, 0, '0, '0);
      // R6: lowest of several matches
      cur_req = "R6";
      step(2'b00, 0, '0, 1, A, ALL);
      // R3 / R5: invalidate hides entry, read keeps data
      cur_req = "R3";
      step(2'b11, 5, '0, 0, '0, '0);
      step(2'b10, 5, '0, 0, '0, '0);
      cur_req = "R5";
      step(2'b00, 0, '0, 1, A, ALL);
      step(2'b11, 9, '0, 0, '0, '0);
      step(2'b00, 0, '0, 1, A, ALL);
      // R7: miss gives zero address
      cur_req = "R7";
      step(2'b00, 0, '0, 1, 64'h5555_5555_5555_5555, ALL);
      // R4: masked compare
      cur_req = "R4";
      step(2'b01, 9, A, 0, '0, '0);
      step(2'b00, 0, '0, 1, A ^ 64'hFF, 64'hFFFF_FFFF_FFFF_FF00);
      step(2'b00, 0, '0, 1, A ^ 64'hFF, ALL);
      step(2'b00, 0, '0, 1, C, 64'hFFFF_FFFF_FFFF_FFFE);
      step(2'b00, 0, '0, 1, '1, '0);
      // R8 / R10: hold without requests
      cur_req = "R8";
      step(2'b00, 0, '0, 0, '0, '0);
      step(2'b01, 12, B, 0, A, '0);
      cur_req = "R10";
      step(2'b00, 0, '0, 0, '0, '0);
      step(2'b11, 3, '0, 0, '0, '0);
      // R9: same-cycle command sees old contents
      cur_req = "R9";
      step(2'b01, 1, C ^ 64'h2, 1, C ^ 64'h2, ALL);
      step(2'b00, 0, '0, 1, C ^ 64'h2, ALL);
      step(2'b11, 1, '0, 1, C ^ 64'h2, ALL);
      step(2'b00, 0, '0, 1, C ^ 64'h2, ALL);
      // random mix over a small address and key pool
      cur_req = "R6";
      for (int n = 0; n < 4000; n++) begin
         int a;
         logic [WIDTH-1:0] d, k, m;
         a = ($urandom % 10 == 0) ? ((($urandom % 2) == 0) ? 0 : 511) : int'($urandom % 16);
         case ($urandom % 4)
            0: d = A; 1: d = B; 2: d = C; default: d = A ^ 64'h10;
         endcase
         case ($urandom % 4)
            0: k = A; 1: k = B; 2: k = C; default: k = {$urandom, $urandom};
         endcase
         case ($urandom % 3)
            0: m = ALL; 1: m = 64'hFFFF_FFFF_FFFF_FF00; default: m = {$urandom, $urandom};
         endcase
         step(2'($urandom % 4), a, d, 1'($urandom % 2), k, m);
      end
      step(2'b00, 0, '0, 0, '0, '0);
      step(2'b00, 0, '0, 0, '0, '0);
      @(negedge clk);
      #1;
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule